// File: doc/BRIEF.md
# 24-Bit Quadrature and Pulse Counter Channel

This block is one counter channel for a data-acquisition card. It counts a 24-bit value from an incremental encoder (A/B phase inputs, decoded at one, two or four counts per cycle) or from an internal prescaled tick. Two preload values hold reload counts. These reloads let the channel measure position, emit one pulse, or run a continuous pulse train on its output pin. An index input can reload the count, and it can also act as a hardware count enable.

The host reaches the channel over a synchronous 16-bit register bus with a 2-bit address. The four registers are count/preload low word (0), count/preload high word (1), mode (2) and command (3). A write is taken on any cycle with `bus_wr` high. A read is requested with `bus_rd`, and its data appears on `bus_rdata` with `bus_rvalid` high one cycle later. The bus has no back-pressure, so every request is accepted in the cycle it is presented. The encoder and index inputs are asynchronous and pass through a two-flop synchroniser. A level change therefore reaches the count on the third rising edge after it.

The 16-bit mode word has these fields. Bit 0 selects the output source (0 = pulse phase, 1 = capture flag). Bit 1 inverts the output. Bits 4:2 hold the reload mode. Bits 6:5 select the hardware enable source. Bits 8:7 hold the enable control. Bits 10:9 select the clock source. Bit 11 is the down direction. Bit 12 selects software direction. Bit 13 selects live high-word reads. Bit 14 selects the preload register. Bit 15 is reserved.

Top module: `gpc_counter24`

## Requirements
- R1: After reset the count, the mode word and the read data are 0, `bus_rvalid` is low and `cnt_out` is low.
- R2: A read answers in the next cycle with `bus_rvalid` high. The mode register reads back bits 14:0 of the last write, with bit 15 always 0. The command register reads as 0.
- R3: A write to address 0 sets bits 15:0, and a write to address 1 sets bits 23:16 from its data bits 7:0, of the preload register named by mode bit 14 (0 = PR0, 1 = PR1). Command bit 14 loads PR0 into the count.
- R4: With mode bit 13 at 0, a low-word read returns count bits 15:0 and captures bits 23:16. The next high-word read returns the captured byte in bits 7:0, with bits 15:8 at 0. With bit 13 at 1, the high-word read returns the live bits 23:16.
- R5: Command bit 15 clears the count to 0 and takes priority over command bit 14 in the same write.
- R6: With clock source 2, every legal {A,B} transition counts one. Transitions along 00→10→11→01→00 count up, and transitions the other way count down.
- R7: Clock source 1 counts only the transitions in which A changes. Clock source 0 counts up on 00→10 and down on 10→00 only.
- R8: A transition in which A and B change together leaves the count unchanged.
- R9: With mode bit 12 at 1, encoder transitions still clock the count, but the direction comes from bit 11 (1 = down).
- R10: Clock source 3 steps the count once every PRESCALE cycles, in the direction given by bit 11. The prescaler restarts on every command write, so the first step comes PRESCALE cycles after that write.
- R11: Enable control 0 freezes the count, and codes 1 and 3 enable it. Code 2 takes the hardware source: 0 = index high, 1 = index low, 2 = capture flag, 3 = capture flag clear.
- R12: With reload mode 4, a rising index edge loads PR0. This load overrides an encoder step that lands in the same cycle.
- R13: A terminal count is a step taken from 0 when counting down, or from all ones when counting up. In reload mode 1 each terminal count toggles the phase and loads PR1 after a PR0 interval and PR0 after a PR1 interval. `cnt_out` is the phase XOR bit 1, so a value N gives an interval of N+1 steps.
- R14: In reload mode 2 the channel runs one PR0 interval then one PR1 interval, then reloads PR0, sets the capture flag and halts. The capture flag is also set on every terminal count in other modes. Command bit 3 clears the flag and the halt, which re-fires a one-shot. With mode bit 0 at 1, `cnt_out` shows the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_idx | input | 1 | Index input (asynchronous) |
| cnt_out | output | 1 | Counter output pin |

## Verification
An index rising edge and an encoder step can reach the count in the same cycle. The bench provokes this by changing the index and one encoder phase on the same clock, so both pass through the synchroniser together. The reload must win, so the count is judged to equal PR0 exactly with no step added. The next lone step must then be counted normally. A command write can likewise coincide with a prescaled tick. Its outcome is judged by the exact count after freezing the channel, and by the measured pulse widths.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  typedef struct packed {
    logic       rsvd;
    logic       pr_sel;
    logic       hi_live;
    logic       dir_sw;
    logic       dir_down;
    logic [1:0] clk_src;
    logic [1:0] en_ctl;
    logic [1:0] en_src;
    logic [2:0] reload;
    logic       out_inv;
    logic       out_src;
  } mode_t;

  localparam logic [1:0] CLK_X1  = 2'd0;
  localparam logic [1:0] CLK_X2  = 2'd1;
  localparam logic [1:0] CLK_X4  = 2'd2;
  localparam logic [1:0] CLK_INT = 2'd3;

  localparam logic [2:0] RL_TRAIN  = 3'd1;
  localparam logic [2:0] RL_SINGLE = 3'd2;
  localparam logic [2:0] RL_INDEX  = 3'd4;

  localparam logic [1:0] EN_OFF = 2'd0;
  localparam logic [1:0] EN_HW  = 2'd2;

  localparam logic [1:0] HS_IDX  = 2'd0;
  localparam logic [1:0] HS_NIDX = 2'd1;
  localparam logic [1:0] HS_CAP  = 2'd2;

  localparam int CMD_RST = 15;
  localparam int CMD_LD  = 14;
  localparam int CMD_CLR = 3;

  localparam logic [1:0] RA_LO   = 2'd0;
  localparam logic [1:0] RA_HI   = 2'd1;
  localparam logic [1:0] RA_MODE = 2'd2;
  localparam logic [1:0] RA_CMD  = 2'd3;
endpackage

// File: rtl/gpc_sync.sv
module gpc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gpc_quad.sv
module gpc_quad
  import gpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a,
  input  logic       b,
  input  logic [1:0] clk_src,
  output logic       step,
  output logic       up
);
  logic [1:0] prev_q;
  logic [1:0] cur;
  logic       fwd;
  logic       rev;
  logic       a_moved;

  assign cur = {a, b};

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= cur;
  end

  // forward order of {A,B}: 00 -> 10 -> 11 -> 01 -> 00
  always_comb begin
    fwd = 1'b0;
    rev = 1'b0;
    unique case ({prev_q, cur})
      4'b0010, 4'b1011, 4'b1101, 4'b0100: fwd = 1'b1;
      4'b1000, 4'b1110, 4'b0111, 4'b0001: rev = 1'b1;
      default: ;
    endcase
  end

  assign a_moved = prev_q[1] ^ cur[1];

  always_comb begin
    unique case (clk_src)
      CLK_X4:  step = fwd | rev;
      CLK_X2:  step = (fwd | rev) & a_moved;
      CLK_X1:  step = ({prev_q, cur} == 4'b0010) | ({prev_q, cur} == 4'b1000);
      default: step = 1'b0;
    endcase
  end

  assign up = fwd;
endmodule

// File: rtl/gpc_core.sv
module gpc_core
  import gpc_pkg::*;
#(
  parameter int CW       = 24,
  parameter int PRESCALE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_t         mode,
  input  logic          pr_wr_lo,
  input  logic          pr_wr_hi,
  input  logic          cmd_wr,
  input  logic [15:0]   wdata,
  input  logic          q_step,
  input  logic          q_up,
  input  logic          idx_lvl,
  input  logic          idx_rise,
  output logic [CW-1:0] cnt,
  output logic          cap,
  output logic          out_pin
);
  localparam int HW = CW - 16;
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [CW-1:0] cnt_q, pr0_q, pr1_q;
  logic [PW-1:0] pre_q;
  logic          ph_q, cap_q, done_q;
  logic          tick, stp, dir_up, hw_en, en, run, at_end, tc;
  logic          c_rst, c_ld, c_clr, idx_ld, tc_eff;
  logic          unused_mode;

  assign unused_mode = ^{mode.rsvd, mode.hi_live};

  assign c_rst  = cmd_wr & wdata[CMD_RST];
  assign c_ld   = cmd_wr & wdata[CMD_LD];
  assign c_clr  = cmd_wr & wdata[CMD_CLR];
  assign idx_ld = idx_rise & (mode.reload == RL_INDEX);

  // preload registers, selected by mode
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pr0_q <= '0;
      pr1_q <= '0;
    end else begin
      if (pr_wr_lo && !mode.pr_sel) pr0_q[15:0]    <= wdata;
      if (pr_wr_lo &&  mode.pr_sel) pr1_q[15:0]    <= wdata;
      if (pr_wr_hi && !mode.pr_sel) pr0_q[CW-1:16] <= wdata[HW-1:0];
      if (pr_wr_hi &&  mode.pr_sel) pr1_q[CW-1:16] <= wdata[HW-1:0];
    end
  end

  // internal prescaled tick, restarted by any command write
  assign tick = (pre_q == PW'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      pre_q <= '0;
    else if (cmd_wr) pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    if (mode.clk_src == CLK_INT) begin
      stp    = tick;
      dir_up = ~mode.dir_down;
    end else begin
      stp    = q_step;
      dir_up = mode.dir_sw ? ~mode.dir_down : q_up;
    end
  end

  always_comb begin
    unique case (mode.en_src)
      HS_IDX:  hw_en = idx_lvl;
      HS_NIDX: hw_en = ~idx_lvl;
      HS_CAP:  hw_en = cap_q;
      default: hw_en = ~cap_q;
    endcase
    unique case (mode.en_ctl)
      EN_OFF:  en = 1'b0;
      EN_HW:   en = hw_en;
      default: en = 1'b1;
    endcase
  end

  assign run    = stp & en & ~done_q;
  assign at_end = dir_up ? (cnt_q == {CW{1'b1}}) : (cnt_q == '0);
  assign tc     = run & at_end;
  assign tc_eff = tc & ~c_rst & ~c_ld & ~idx_ld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      done_q <= 1'b0;
      cap_q  <= 1'b0;
    end else begin
      if (c_rst) begin
        cnt_q  <= '0;
        ph_q   <= 1'b0;
        done_q <= 1'b0;
      end else if (c_ld) begin
        cnt_q  <= pr0_q;
        ph_q   <= 1'b0;
        done_q <= 1'b0;
      end else if (idx_ld) begin
        cnt_q <= pr0_q;
      end else if (run) begin
        if (tc && mode.reload == RL_TRAIN) begin
          cnt_q <= ph_q ? pr0_q : pr1_q;
          ph_q  <= ~ph_q;
        end else if (tc && mode.reload == RL_SINGLE) begin
          if (!ph_q) begin
            cnt_q <= pr1_q;
            ph_q  <= 1'b1;
          end else begin
            cnt_q  <= pr0_q;
            ph_q   <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          cnt_q <= dir_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
        end
      end
      if (c_clr) begin
        cap_q  <= 1'b0;
        done_q <= 1'b0;
      end else if (tc_eff && (mode.reload != RL_SINGLE || ph_q)) begin
        cap_q <= 1'b1;
      end
    end
  end

  assign cnt     = cnt_q;
  assign cap     = cap_q;
  assign out_pin = (mode.out_src ? cap_q : ph_q) ^ mode.out_inv;
endmodule

// File: rtl/gpc_counter24.sv
module gpc_counter24
  import gpc_pkg::*;
#(
  parameter int CW          = 24,
  parameter int PRESCALE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_rvalid,
  input  logic        enc_a,
  input  logic        enc_b,
  input  logic        enc_idx,
  output logic        cnt_out
);
  localparam int HW = CW - 16;

  mode_t         mode_q;
  logic [HW-1:0] snap_q;
  logic [15:0]   rdata_q;
  logic          rvalid_q;
  logic [2:0]    pins_s;
  logic          idx_prev_q, idx_rise;
  logic          q_step, q_up;
  logic [CW-1:0] cnt_w;
  logic          cap_w;
  logic [HW-1:0] hi_sel;

  gpc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({enc_a, enc_b, enc_idx}),
    .dout (pins_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) idx_prev_q <= 1'b0;
    else        idx_prev_q <= pins_s[0];
  end
  assign idx_rise = pins_s[0] & ~idx_prev_q;

  gpc_quad u_quad (
    .clk    (clk),
    .rst_n  (rst_n),
    .a      (pins_s[2]),
    .b      (pins_s[1]),
    .clk_src(mode_q.clk_src),
    .step   (q_step),
    .up     (q_up)
  );

  gpc_core #(.CW(CW), .PRESCALE(PRESCALE)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .pr_wr_lo(bus_wr && bus_addr == RA_LO),
    .pr_wr_hi(bus_wr && bus_addr == RA_HI),
    .cmd_wr  (bus_wr && bus_addr == RA_CMD),
    .wdata   (bus_wdata),
    .q_step  (q_step),
    .q_up    (q_up),
    .idx_lvl (pins_s[0]),
    .idx_rise(idx_rise),
    .cnt     (cnt_w),
    .cap     (cap_w),
    .out_pin (cnt_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                          mode_q <= '0;
    else if (bus_wr && bus_addr == RA_MODE) mode_q <= mode_t'({1'b0, bus_wdata[14:0]});
  end

  assign hi_sel = mode_q.hi_live ? cnt_w[CW-1:16] : snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      snap_q   <= '0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) begin
        unique case (bus_addr)
          RA_LO: begin
            rdata_q <= cnt_w[15:0];
            if (!mode_q.hi_live) snap_q <= cnt_w[CW-1:16];
          end
          RA_HI:   rdata_q <= {{(16-HW){1'b0}}, hi_sel};
          RA_MODE: rdata_q <= {1'b0, mode_q[14:0]};
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/gpc_chk.sv
module gpc_chk #(
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [1:0]    bus_addr,
  input logic [15:0]   bus_wdata,
  input logic [15:0]   bus_rdata,
  input logic          bus_rvalid,
  input logic [15:0]   mode,
  input logic [CW-1:0] cnt,
  input logic          cap,
  input logic          idx_rise
);
  logic cmd_w, idx_ld;
  assign cmd_w  = bus_wr && bus_addr == 2'd3;
  assign idx_ld = idx_rise && mode[4:2] == 3'd4;

  AST_READ_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R2

  AST_HIGH_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd1) |=> ((bus_rdata >> (CW - 16)) == 16'd0)); // R4

  AST_RESET_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && bus_wdata[15]) |=> (cnt == '0)); // R5

  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[8:7] == 2'd0 && !cmd_w && !idx_ld) |=> $stable(cnt)); // R11

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && bus_wdata[3]) |=> !cap); // R14
endmodule

bind gpc_counter24 gpc_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid),
  .mode      (mode_q),
  .cnt       (cnt_w),
  .cap       (cap_w),
  .idx_rise  (idx_rise)
);

// File: tb/gpc_counter24_bench.sv
`timescale 1ns/1ps
module gpc_counter24_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
  logic        cnt_out;

  int total = 0;
  int bad = 0;
  logic last_rv;

  always #2.5 clk = ~clk;

  gpc_counter24 u_gpc_counter24 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .enc_a(enc_a), .enc_b(enc_b),
    .enc_idx(enc_idx), .cnt_out(cnt_out)
  );

  // {kind, clock source, {A,B}, expected count}; kind 0=R6 1=R7 2=R8
  localparam logic [29:0] QV [26] = '{
    {2'd0, 2'd2, 2'b10, 24'd101}, {2'd0, 2'd2, 2'b11, 24'd102},
    {2'd0, 2'd2, 2'b01, 24'd103}, {2'd0, 2'd2, 2'b00, 24'd104},
    {2'd0, 2'd2, 2'b01, 24'd103}, {2'd0, 2'd2, 2'b11, 24'd102},
    {2'd2, 2'd2, 2'b00, 24'd102}, {2'd0, 2'd2, 2'b10, 24'd103},
    {2'd2, 2'd2, 2'b01, 24'd103}, {2'd0, 2'd2, 2'b00, 24'd104},
    {2'd1, 2'd1, 2'b10, 24'd101}, {2'd1, 2'd1, 2'b11, 24'd101},
    {2'd1, 2'd1, 2'b01, 24'd102}, {2'd1, 2'd1, 2'b00, 24'd102},
    {2'd1, 2'd1, 2'b01, 24'd102}, {2'd1, 2'd1, 2'b11, 24'd101},
    {2'd1, 2'd1, 2'b10, 24'd101}, {2'd1, 2'd1, 2'b00, 24'd100},
    {2'd1, 2'd0, 2'b10, 24'd101}, {2'd1, 2'd0, 2'b11, 24'd101},
    {2'd1, 2'd0, 2'b01, 24'd101}, {2'd1, 2'd0, 2'b00, 24'd101},
    {2'd1, 2'd0, 2'b01, 24'd101}, {2'd1, 2'd0, 2'b11, 24'd101},
    {2'd1, 2'd0, 2'b10, 24'd101}, {2'd1, 2'd0, 2'b00, 24'd100}
  };

  function automatic logic [15:0] md(input logic [1:0] ck, input logic [1:0] ectl,
      input logic [1:0] esrc, input logic [2:0] rl, input logic dn, input logic dsw,
      input logic inv, input logic osrc, input logic live, input logic sel);
    return {1'b0, sel, live, dsw, dn, ck, ectl, esrc, rl, inv, osrc};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata; last_rv = bus_rvalid;
  endtask

  task automatic rd_cnt(output logic [23:0] v);
    logic [15:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    v = {hi[7:0], lo};
  endtask

  task automatic quad(input logic [1:0] ab);
    @(negedge clk); enc_a = ab[1]; enc_b = ab[0];
    repeat (4) @(negedge clk);
  endtask

  task automatic set_pr(input logic sel, input logic [23:0] v);
    wr(2'd2, md(2'd0, 2'd0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, sel));
    wr(2'd1, {8'h00, v[23:16]});
    wr(2'd0, v[15:0]);
  endtask

  task automatic wait_level(input logic lvl);
    for (int i = 0; i < 200 && cnt_out !== lvl; i++) @(negedge clk);
  endtask

  task automatic count_level(input logic lvl, input int lim, output int n);
    n = 0;
    while (cnt_out === lvl && n < lim) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [23:0] v;
    logic [1:0]  prev_ck;
    int          n;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 out", {31'd0, cnt_out}, 32'd0);
    chk("R1 rvalid", {31'd0, bus_rvalid}, 32'd0);
    chk("R1 rdata", {16'd0, bus_rdata}, 32'd0);
    rd_cnt(v);
    chk("R1 count", {8'd0, v}, 32'd0);
    rd(2'd2, d);
    chk("R1 mode", {16'd0, d}, 32'd0);

    // R2 register map and read timing
    wr(2'd2, 16'hFFFF);
    rd(2'd2, d);
    chk("R2 mode readback", {16'd0, d}, 32'h7FFF);
    chk("R2 rvalid", {31'd0, last_rv}, 32'd1);
    rd(2'd3, d);
    chk("R2 command reads 0", {16'd0, d}, 32'd0);

    // R3 preload select
    set_pr(1'b0, 24'h123456);
    wr(2'd1, 16'hAB12);
    set_pr(1'b1, 24'h778899);
    wr(2'd3, 16'h4000);
    rd_cnt(v);
    chk("R3 load from PR0", {8'd0, v}, 32'h123456);

    // R4 latch on low read
    wr(2'd2, 16'h0000);
    rd(2'd0, d);
    chk("R4 low word", {16'd0, d}, 32'h3456);
    wr(2'd3, 16'h8000);
    rd(2'd1, d);
    chk("R4 captured high byte", {16'd0, d}, 32'h0012);
    wr(2'd3, 16'h4000);
    rd(2'd0, d);
    wr(2'd3, 16'h8000);
    wr(2'd2, 16'h2000);
    rd(2'd1, d);
    chk("R4 live high byte", {16'd0, d}, 32'h0000);

    // R5 reset beats load
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h4000);
    wr(2'd3, 16'hC000);
    rd_cnt(v);
    chk("R5 reset priority", {8'd0, v}, 32'd0);

    // R6 R7 R8 quadrature table
    set_pr(1'b0, 24'd100);
    prev_ck = 2'b11;
    foreach (QV[i]) begin
      if (QV[i][27:26] != prev_ck) begin
        prev_ck = QV[i][27:26];
        wr(2'd2, md(prev_ck, 2'd1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        wr(2'd3, 16'h4000);
      end
      quad(QV[i][25:24]);
      rd_cnt(v);
      case (QV[i][29:28])
        2'd0:    chk("R6 x4 step", {8'd0, v}, {8'd0, QV[i][23:0]});
        2'd1:    chk("R7 x2/x1 step", {8'd0, v}, {8'd0, QV[i][23:0]});
        default: chk("R8 illegal ignored", {8'd0, v}, {8'd0, QV[i][23:0]});
      endcase
    end

    // R9 software direction
    wr(2'd2, md(2'd2, 2'd1, 2'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(2'd3, 16'h4000);
    quad(2'b10); quad(2'b11); quad(2'b01); quad(2'b00);
    rd_cnt(v);
    chk("R9 forced down", {8'd0, v}, 32'd96);
    wr(2'd2, md(2'd2, 2'd1, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    quad(2'b01);
    rd_cnt(v);
    chk("R9 forced up", {8'd0, v}, 32'd97);

    // R10 internal prescaled clock
    set_pr(1'b0, 24'd0);
    wr(2'd2, md(2'd3, 2'd1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(2'd3, 16'h4000);
    repeat (40) @(negedge clk);
    wr(2'd2, md(2'd3, 2'd0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    rd_cnt(v);
    chk("R10 ticks", {8'd0, v}, 32'd10);
    repeat (20) @(negedge clk);
    rd_cnt(v);
    chk("R11 disabled holds", {8'd0, v}, 32'd10);

    // R11 hardware enable from index
    set_pr(1'b0, 24'd100);
    wr(2'd2, md(2'd2, 2'd2, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(2'd3, 16'h4000);
    quad(2'b10);
    rd_cnt(v);
    chk("R11 index low blocks", {8'd0, v}, 32'd100);
    enc_idx = 1'b1;
    repeat (4) @(negedge clk);
    quad(2'b11);
    rd_cnt(v);
    chk("R11 index high enables", {8'd0, v}, 32'd101);
    wr(2'd2, md(2'd2, 2'd2, 2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    quad(2'b01);
    rd_cnt(v);
    chk("R11 inverted index blocks", {8'd0, v}, 32'd101);
    enc_idx = 1'b0;
    quad(2'b00);
    rd_cnt(v);
    chk("R11 inverted index enables", {8'd0, v}, 32'd102);

    // R12 index reload, coinciding with a step
    wr(2'd2, md(2'd2, 2'd1, 2'd0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(2'd3, 16'h4000);
    quad(2'b10); quad(2'b11); quad(2'b01);
    rd_cnt(v);
    chk("R12 before index", {8'd0, v}, 32'd103);
    @(negedge clk); enc_idx = 1'b1; enc_a = 1'b0; enc_b = 1'b0;
    repeat (4) @(negedge clk);
    rd_cnt(v);
    chk("R12 index beats step", {8'd0, v}, 32'd100);
    enc_idx = 1'b0;
    repeat (4) @(negedge clk);
    quad(2'b10);
    rd_cnt(v);
    chk("R12 step after reload", {8'd0, v}, 32'd101);

    // R13 pulse train
    set_pr(1'b0, 24'd3);
    set_pr(1'b1, 24'd1);
    wr(2'd2, md(2'd3, 2'd1, 2'd0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(2'd3, 16'h4000);
    wait_level(1'b1);
    count_level(1'b1, 200, n);
    chk("R13 PR1 interval", n, 32'd8);
    count_level(1'b0, 200, n);
    chk("R13 PR0 interval", n, 32'd16);
    wr(2'd2, md(2'd3, 2'd1, 2'd0, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    wait_level(1'b0);
    wait_level(1'b1);
    count_level(1'b1, 200, n);
    chk("R13 inverted PR0 interval", n, 32'd16);
    count_level(1'b0, 200, n);
    chk("R13 inverted PR1 interval", n, 32'd8);

    // R14 single pulse, one-shot through capture flag
    wr(2'd2, md(2'd3, 2'd2, 2'd3, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(2'd3, 16'h4008);
    count_level(1'b0, 200, n);
    chk("R14 lead interval", n, 32'd16);
    count_level(1'b1, 200, n);
    chk("R14 pulse width", n, 32'd8);
    count_level(1'b0, 60, n);
    chk("R14 stays low", n, 32'd60);
    rd_cnt(v);
    chk("R14 halted at PR0", {8'd0, v}, 32'd3);
    wr(2'd2, md(2'd3, 2'd2, 2'd3, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
    chk("R14 flag shown", {31'd0, cnt_out}, 32'd1);
    wr(2'd3, 16'h0008);
    count_level(1'b0, 200, n);
    chk("R14 re-fire to flag", n, 32'd24);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule